// File: doc/BRIEF.md
# Serial Flash Write-Protection Gate

This block decides whether a decoded data-modifying command in a serial NOR flash model may run. A command decoder upstream hands it a command class, the number of serial clocks counted during the transaction, and a strobe marking the moment chip select is released. The gate combines several checks into one accept or refuse decision at that strobe:

- the write enable latch must be set;
- the transaction length must be a whole number of bytes;
- a power-up lockout timer must have expired;
- the targeted 64 KB sector must not be locked;
- a status write must not be frozen by the hardware protect pin.

An accepted command produces a one-cycle execute permit and marks the gate busy. The busy state holds until the outside program/erase engine returns a done pulse, which also clears the write enable latch. A refused command raises a one-cycle reject flag. A command of the wrong length is dropped silently.

Top module: `wpGate`

## Requirements
- R1: After reset, and on any cycle where powerGood is low, wel, busy, execPermit and reject are 0 at the following clock edge.
- R2: With busy low, a csRise with opCode 1 (write enable) sets wel and opCode 2 (write disable) clears wel, regardless of clkCount, lock bits, protect pin or lockout.
- R3: With busy low, a modify command whose length is accepted and whose wel is 0 gives reject=1 for one cycle, execPermit=0, and leaves wel at 0. Modify commands are opCode 3 program, 4 subsector erase, 5 sector erase, 6 bulk erase, 7 status write, 8 lock-register write and 9 OTP program.
- R4: For opCodes 3, 4, 5, 6, 7 and 9, a csRise with clkCount not a multiple of 8 is dropped: no execPermit, no reject, wel unchanged. OpCode 8 is not length-checked.
- R5: Program, subsector erase or sector erase (3, 4, 5) with sectorLocks[sectorAddr]=1 is rejected. Bulk erase (6) is rejected when any lock bit is set.
- R6: A status write (7) while wpPin=1 is rejected.
- R7: An accepted command raises execPermit for exactly one cycle, in the cycle after csRise. busy rises in the same cycle, and wel stays 1.
- R8: While busy is 1, every csRise is ignored, including write enable and write disable: no execPermit, no reject, wel unchanged.
- R9: An opDone while busy clears busy and wel at the next edge. A csRise in that same cycle is ignored. An opDone while idle has no effect.
- R10: For PUW_CYCLES cycles after reset release or after powerGood returns high, every otherwise valid modify command is rejected. After that window it is accepted.
- R11: OpCodes 0 and 10 to 15 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| powerGood | input | 1 | Supply valid; low acts as power-up |
| csRise | input | 1 | One-cycle strobe at chip-select release |
| opCode | input | 4 | Decoded command class |
| clkCount | input | CNT_W | Serial clocks counted in the transaction |
| sectorAddr | input | $clog2(NUM_SECT) | Target 64 KB sector |
| sectorLocks | input | NUM_SECT | Per-sector lock bits |
| wpPin | input | 1 | Hardware write-protect, freezes status writes |
| opDone | input | 1 | Completion pulse from the operation engine |
| execPermit | output | 1 | One-cycle permission to execute |
| wel | output | 1 | Write enable latch |
| busy | output | 1 | Operation in progress |
| reject | output | 1 | One-cycle refusal flag |

## Verification
The completion pulse and the release of chip select for a new command can fall in the same cycle. The gate must then finish the running operation and ignore the new command rather than start it. The bench provokes this by presenting opDone together with a csRise that carries a write enable, and again with one that carries a program. It judges the following cycle by requiring busy and wel both at 0, with neither execPermit nor reject raised. A sweep over command class, length, wel state, sector, lock pattern and protect pin checks every outcome against an arithmetic model.

// File: rtl/wpgate_pkg.sv
package wpgate_pkg;
  localparam logic [3:0] OP_NOP       = 4'd0;
  localparam logic [3:0] OP_WREN      = 4'd1;
  localparam logic [3:0] OP_WRDI      = 4'd2;
  localparam logic [3:0] OP_PROG      = 4'd3;
  localparam logic [3:0] OP_SUBERASE  = 4'd4;
  localparam logic [3:0] OP_SECTERASE = 4'd5;
  localparam logic [3:0] OP_BULKERASE = 4'd6;
  localparam logic [3:0] OP_WRSTAT    = 4'd7;
  localparam logic [3:0] OP_WRLOCK    = 4'd8;
  localparam logic [3:0] OP_OTPPROG   = 4'd9;

  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic fire;
    logic refuse;
    logic clrBusy;
  } ctrlStrobe_t;

  typedef struct packed {
    logic aligned;
    logic sectLocked;
    logic anyLocked;
    logic lockout;
    logic wel;
    logic busy;
  } dpStatus_t;
endpackage

// File: rtl/wpgateCtrl.sv
module wpgateCtrl
  import wpgate_pkg::*;
(
  input  logic        csRise,
  input  logic [3:0]  opCode,
  input  logic        opDone,
  input  logic        wpPin,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe
);
  logic isModify;
  logic needsAlign;
  logic hitsSector;
  logic blocked;

  always_comb begin
    isModify   = (opCode >= OP_PROG) && (opCode <= OP_OTPPROG);
    needsAlign = isModify && (opCode != OP_WRLOCK);
    hitsSector = (opCode == OP_PROG) || (opCode == OP_SUBERASE) ||
                 (opCode == OP_SECTERASE);
    blocked    = status.lockout || !status.wel ||
                 (hitsSector && status.sectLocked) ||
                 ((opCode == OP_BULKERASE) && status.anyLocked) ||
                 ((opCode == OP_WRSTAT) && wpPin);
  end

  always_comb begin
    strobe = '0;
    if (status.busy) begin
      if (opDone) begin
        strobe.clrBusy = 1'b1;
        strobe.clrWel  = 1'b1;
      end
    end else if (csRise) begin
      if (opCode == OP_WREN) begin
        strobe.setWel = 1'b1;
      end else if (opCode == OP_WRDI) begin
        strobe.clrWel = 1'b1;
      end else if (isModify && !(needsAlign && !status.aligned)) begin
        if (blocked) strobe.refuse = 1'b1;
        else         strobe.fire   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/wpgateDp.sv
module wpgateDp
  import wpgate_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int NUM_SECT   = 256,
  parameter int PUW_CYCLES = 1000
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        powerGood,
  input  logic [CNT_W-1:0]            clkCount,
  input  logic [$clog2(NUM_SECT)-1:0] sectorAddr,
  input  logic [NUM_SECT-1:0]         sectorLocks,
  input  ctrlStrobe_t                 strobe,
  output dpStatus_t                   status,
  output logic                        wel,
  output logic                        busy,
  output logic                        execPermit,
  output logic                        reject
);
  localparam int TMR_W = $clog2(PUW_CYCLES + 1);
  localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(PUW_CYCLES);

  logic [TMR_W-1:0] lockTmr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  lockTmr <= TMR_LOAD;
    else if (!powerGood)        lockTmr <= TMR_LOAD;
    else if (lockTmr != '0)     lockTmr <= lockTmr - TMR_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wel <= 1'b0; busy <= 1'b0; execPermit <= 1'b0; reject <= 1'b0;
    end else if (!powerGood) begin
      wel <= 1'b0; busy <= 1'b0; execPermit <= 1'b0; reject <= 1'b0;
    end else begin
      execPermit <= strobe.fire;
      reject     <= strobe.refuse;
      if (strobe.clrWel)      wel <= 1'b0;
      else if (strobe.setWel) wel <= 1'b1;
      if (strobe.fire)         busy <= 1'b1;
      else if (strobe.clrBusy) busy <= 1'b0;
    end
  end

  always_comb begin
    status.aligned    = (clkCount[2:0] == 3'd0);
    status.sectLocked = sectorLocks[sectorAddr];
    status.anyLocked  = |sectorLocks;
    status.lockout    = (lockTmr != '0);
    status.wel        = wel;
    status.busy       = busy;
  end

  // R7
  fire_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    execPermit |=> !execPermit);
  // R7
  permit_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(execPermit && reject));
  // R7
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> execPermit);
endmodule

// File: rtl/wpGate.sv
module wpGate
  import wpgate_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int NUM_SECT   = 256,
  parameter int PUW_CYCLES = 1000
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        powerGood,
  input  logic                        csRise,
  input  logic [3:0]                  opCode,
  input  logic [CNT_W-1:0]            clkCount,
  input  logic [$clog2(NUM_SECT)-1:0] sectorAddr,
  input  logic [NUM_SECT-1:0]         sectorLocks,
  input  logic                        wpPin,
  input  logic                        opDone,
  output logic                        execPermit,
  output logic                        wel,
  output logic                        busy,
  output logic                        reject
);
  ctrlStrobe_t strobe;
  dpStatus_t   status;

  wpgateCtrl u_ctrl (
    .csRise (csRise),
    .opCode (opCode),
    .opDone (opDone),
    .wpPin  (wpPin),
    .status (status),
    .strobe (strobe)
  );

  wpgateDp #(
    .CNT_W      (CNT_W),
    .NUM_SECT   (NUM_SECT),
    .PUW_CYCLES (PUW_CYCLES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .powerGood   (powerGood),
    .clkCount    (clkCount),
    .sectorAddr  (sectorAddr),
    .sectorLocks (sectorLocks),
    .strobe      (strobe),
    .status      (status),
    .wel         (wel),
    .busy        (busy),
    .execPermit  (execPermit),
    .reject      (reject)
  );

  // R10
  lockout_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    execPermit |-> (!$past(status.lockout) && $past(wel)));
  // R9
  done_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && opDone) |=> (!busy && !wel));
  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !opDone && powerGood) |=> $stable(wel));
  // R1
  power_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !powerGood |=> (!wel && !busy && !execPermit && !reject));
endmodule

// File: tb/wpGate_bench.sv
module wpGate_bench;
  localparam int CNT_W = 6;
  localparam int NUM_SECT = 4;
  localparam int PUW = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic powerGood = 1'b1;
  logic csRise = 1'b0;
  logic [3:0] opCode = 4'd0;
  logic [CNT_W-1:0] clkCount = '0;
  logic [1:0] sectorAddr = '0;
  logic [NUM_SECT-1:0] sectorLocks = '0;
  logic wpPin = 1'b0;
  logic opDone = 1'b0;
  logic execPermit, wel, busy, reject;

  int nChecks = 0;
  int nFails = 0;
  bit mWel = 0;
  bit mBusy = 0;
  bit mLockout = 0;

  always #10 clk = ~clk;

  wpGate #(.CNT_W(CNT_W), .NUM_SECT(NUM_SECT), .PUW_CYCLES(PUW)) u_wpGate (
    .clk(clk), .rstN(rstN), .powerGood(powerGood), .csRise(csRise),
    .opCode(opCode), .clkCount(clkCount), .sectorAddr(sectorAddr),
    .sectorLocks(sectorLocks), .wpPin(wpPin), .opDone(opDone),
    .execPermit(execPermit), .wel(wel), .busy(busy), .reject(reject));

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag, input int eP, input int eR);
    check({tag, " execPermit"}, execPermit, eP);
    check({tag, " reject"}, reject, eR);
    check({tag, " wel"}, wel, mWel);
    check({tag, " busy"}, busy, mBusy);
  endtask

  // outcome: 0 nothing, 1 permit, 2 reject
  function automatic int expOutcome(input int op, input int cnt, input int sect,
                                    input bit wEn, input bit bsy, input logic [3:0] lk,
                                    input bit wp, input bit lo);
    if (bsy) return 0;
    if (op < 3 || op > 9) return 0;
    if (op != 8 && (cnt % 8) != 0) return 0;
    if (lo || !wEn) return 2;
    if (op >= 3 && op <= 5 && lk[sect]) return 2;
    if (op == 6 && lk != 0) return 2;
    if (op == 7 && wp) return 2;
    return 1;
  endfunction

  function automatic string reason(input int op, input int cnt, input int sect,
                                   input bit wEn, input bit bsy, input logic [3:0] lk,
                                   input bit wp, input bit lo);
    if (bsy) return "R8";
    if (op == 1 || op == 2) return "R2";
    if (op < 3 || op > 9) return "R11";
    if (op != 8 && (cnt % 8) != 0) return "R4";
    if (lo) return "R10";
    if (!wEn) return "R3";
    if ((op >= 3 && op <= 5 && lk[sect]) || (op == 6 && lk != 0)) return "R5";
    if (op == 7 && wp) return "R6";
    return "R7";
  endfunction

  task automatic sendCmd(input int op, input int cnt, input int sect, input bit done);
    int res;
    string tag;
    res = expOutcome(op, cnt, sect, mWel, mBusy, sectorLocks, wpPin, mLockout);
    tag = reason(op, cnt, sect, mWel, mBusy, sectorLocks, wpPin, mLockout);
    if (done && mBusy) tag = "R9";
    @(negedge clk);
    csRise = 1'b1; opCode = op[3:0]; clkCount = cnt[CNT_W-1:0];
    sectorAddr = sect[1:0]; opDone = done;
    @(negedge clk);
    csRise = 1'b0; opDone = 1'b0;
    if (mBusy) begin
      if (done) begin mBusy = 0; mWel = 0; end
    end else begin
      if (op == 1) mWel = 1;
      if (op == 2) mWel = 0;
      if (res == 1) mBusy = 1;
    end
    checkAll(tag, (res == 1) ? 1 : 0, (res == 2) ? 1 : 0);
  endtask

  task automatic pulseDone();
    @(negedge clk);
    opDone = 1'b1;
    @(negedge clk);
    opDone = 1'b0;
    if (mBusy) begin mBusy = 0; mWel = 0; end
    checkAll("R9 done", 0, 0);
  endtask

  task automatic idleCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    idleCycles(3);
    rstN = 1'b1;
    mLockout = 1;
    @(negedge clk);
    // R1 reset state
    checkAll("R1 reset", 0, 0);
    // R10: write enable works during lockout, program is refused
    sendCmd(1, 8, 0, 0);
    sendCmd(3, 32, 0, 0);
    idleCycles(PUW + 4);
    mLockout = 0;
    sendCmd(3, 32, 0, 0);
    pulseDone();

    // Main sweep
    for (int lkSel = 0; lkSel < 2; lkSel++) begin
      sectorLocks = (lkSel == 0) ? 4'b0000 : 4'b0100;
      for (int wp = 0; wp < 2; wp++) begin
        wpPin = wp[0];
        for (int wEn = 0; wEn < 2; wEn++) begin
          for (int op = 0; op < 12; op++) begin
            for (int cnt = 6; cnt < 18; cnt++) begin
              for (int sect = 0; sect < 4; sect++) begin
                sendCmd(wEn ? 1 : 2, 8, 0, 0);
                sendCmd(op, cnt, sect, 0);
                if (mBusy) begin
                  sendCmd(1, 8, 0, 0);   // R8 enable ignored while busy
                  sendCmd(2, 8, 0, 0);   // R8 disable ignored while busy
                  pulseDone();
                end
              end
            end
          end
        end
      end
    end
    wpPin = 1'b0;
    sectorLocks = '0;

    // R9 opDone while idle has no effect
    sendCmd(1, 8, 0, 0);
    pulseDone();

    // R9 same-cycle done and write enable
    sendCmd(3, 16, 1, 0);
    sendCmd(1, 8, 0, 1);
    // R9 same-cycle done and program
    sendCmd(1, 8, 0, 0);
    sendCmd(5, 24, 2, 0);
    sendCmd(3, 16, 0, 1);
    check("R9 same-cycle program stays idle", busy, 0);

    // R1 power loss clears state, R10 lockout restarts
    sendCmd(1, 8, 0, 0);
    sendCmd(4, 40, 3, 0);
    @(negedge clk);
    powerGood = 1'b0;
    idleCycles(3);
    mWel = 0; mBusy = 0;
    checkAll("R1 power loss", 0, 0);
    powerGood = 1'b1;
    mLockout = 1;
    sendCmd(1, 8, 0, 0);
    sendCmd(7, 16, 0, 0);
    idleCycles(PUW + 4);
    mLockout = 0;
    sendCmd(7, 16, 0, 0);
    pulseDone();

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule